// File: doc/BRIEF.md
# Sampling ADC Conversion and Serial Controller

This block sits on the host side of a serially attached 12-bit sampling converter and runs it at a fixed sample rate. A free-running period timer requests one conversion per period. In hardware-start mode the block raises a conversion-start strobe of programmed width, waits for the converter's busy line to rise, and then, while that conversion is still in progress, runs one full-duplex 16-bit framed serial transfer. The transfer sends the host's control word MSB first and collects the result of the previous conversion. Running the transfer during the conversion is what lets the sample rate reach the converter's limit.

After busy falls, the block holds off the next start for a programmed acquisition gap so that the track-and-hold can settle. Each received frame yields a 12-bit straight-binary result on a one-cycle valid strobe. In software-start mode no strobe is issued: the frame itself starts the conversion, and busy is tracked afterwards. A sticky overrun flag reports a period that expired while the converter was still busy. All timings are parameters counted in system-clock cycles.

Top module: `adc_sample_ctrl`

## Requirements
- R1: In hardware-start mode each conversion begins with `conv_start` high for exactly START_W consecutive cycles.
- R2: In hardware-start mode the serial frame (`sync_n` low) starts only while the converter's `busy` is high, so that the transfer overlaps the conversion.
- R3: At least ACQ_CYC cycles pass between `busy` falling and the next rising edge of `conv_start`.
- R4: A frame holds `sync_n` low for exactly 16 rising edges of `sclk`. `sclk` idles low, and `mosi` carries `ctrl_word` bit 15 first, changing only on falling edges of `sclk` (or when the frame opens), so it is stable at every rising edge.
- R5: `miso` is sampled on each rising edge of `sclk`. The result is bits 11..0 of the 16 received bits (the first received bit is bit 15), and the upper four bits are discarded.
- R6: `res_valid` is high for exactly one cycle, the cycle in which `sync_n` returns high. `res_data` then holds the result of the conversion before the one during which the frame ran.
- R7: With `enable` held high and no overrun, successive conversion starts are exactly SAMPLE_PERIOD cycles apart.
- R8: `overrun` is set when a sample period expires while the synchronised `busy` is high. It stays set until reset.
- R9: With `sw_start` high, `conv_start` never rises. Each period instead sends one frame, and the block then waits for the busy cycle that the frame triggers.
- R10: Synchronous reset drives `conv_start`=0, `sync_n`=1, `sclk`=0, `res_valid`=0 and `overrun`=0.
- R11: While `enable` is low, no new conversion or frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the sample-period timer |
| sw_start | input | 1 | 1: conversion started by the serial frame; 0: by the strobe |
| ctrl_word | input | 16 | Word shifted out in every frame |
| busy | input | 1 | Converter busy (asynchronous, synchronised inside) |
| miso | input | 1 | Serial data from the converter |
| conv_start | output | 1 | Conversion-start strobe |
| sclk | output | 1 | Serial clock |
| sync_n | output | 1 | Frame enable, active low |
| mosi | output | 1 | Serial data to the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Latest conversion result |
| overrun | output | 1 | Sticky late-busy flag |

## Verification
A sequencer stuck in the wrong state shows within one sample period. It appears as a missing or stretched `conv_start`, a frame that opens while `busy` is low, or a start that comes too soon after `busy` falls. A shifter that is off by one bit or one edge shows on the next `res_valid`, as a result shifted against the converter model's table value, or as a frame that does not have 16 clock rises. Timer faults show as start-to-start spacing that differs from the period, or as an `overrun` that appears, or fails to appear, at the first late period.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_PULSE = 3'd1,
    SQ_WAITB = 3'd2,
    SQ_CONV  = 3'd3,
    SQ_ACQ   = 3'd4,
    SQ_SWF   = 3'd5
  } seq_state_t;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/period_timer.sv
module period_timer #(
  parameter int SAMPLE_PERIOD = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic busy_s,
  output logic tick,
  output logic overrun
);
  localparam int CW = adc_ctrl_pkg::cnt_width(SAMPLE_PERIOD);
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tick    <= 1'b0;
      overrun <= 1'b0;
    end else if (!enable) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
      if (busy_s) overrun <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R11
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !tick);

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import adc_ctrl_pkg::*;
#(
  parameter int START_W = 25,
  parameter int ACQ_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sw_mode,
  input  logic busy_s,
  input  logic frame_busy,
  input  logic frame_done,
  output logic conv_start,
  output logic frame_go
);
  localparam int MAXC = (START_W > ACQ_CYC) ? START_W : ACQ_CYC;
  localparam int CW   = cnt_width(MAXC);
  localparam int GW   = cnt_width(ACQ_CYC + 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(START_W - 1);
  localparam logic [CW-1:0] ACQ_LAST   = CW'(ACQ_CYC - 1);
  localparam logic [GW-1:0] GAP_MAX    = GW'(ACQ_CYC);

  seq_state_t    st;
  logic [CW-1:0] cnt;
  logic          pending;
  logic          mode_q;
  logic          launch;
  logic [GW-1:0] gap_cnt;

  assign launch = (st == SQ_IDLE) && pending && !frame_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      cnt        <= '0;
      pending    <= 1'b0;
      mode_q     <= 1'b0;
      conv_start <= 1'b0;
      frame_go   <= 1'b0;
    end else begin
      pending  <= (pending & ~launch) | tick;
      frame_go <= 1'b0;
      case (st)
        SQ_IDLE: if (launch) begin
          mode_q <= sw_mode;
          cnt    <= '0;
          if (sw_mode) begin
            frame_go <= 1'b1;
            st       <= SQ_SWF;
          end else begin
            conv_start <= 1'b1;
            st         <= SQ_PULSE;
          end
        end
        SQ_PULSE: begin
          if (cnt == PULSE_LAST) begin
            conv_start <= 1'b0;
            st         <= SQ_WAITB;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_SWF: if (frame_done) st <= SQ_WAITB;
        SQ_WAITB: if (busy_s) begin
          if (!mode_q) frame_go <= 1'b1;
          st <= SQ_CONV;
        end
        SQ_CONV: if (!busy_s) begin
          cnt <= '0;
          st  <= SQ_ACQ;
        end
        SQ_ACQ: begin
          if (cnt == ACQ_LAST) st <= SQ_IDLE;
          else                 cnt <= cnt + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // Independent watch on the settling time since busy was last seen high.
  always_ff @(posedge clk) begin
    if (rst)                   gap_cnt <= GAP_MAX;
    else if (busy_s)           gap_cnt <= '0;
    else if (gap_cnt < GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
  end

  // R3
  acq_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start) |-> (gap_cnt >= GAP_MAX));

  // R2
  overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_go && !mode_q) |-> busy_s);

  // R9
  sw_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> !conv_start);

  // R1
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_start && cnt != PULSE_LAST) |=> conv_start);

endmodule

// File: rtl/serial_frame.sv
module serial_frame #(
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 12,
  parameter int SCLK_HALF  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [FRAME_BITS-1:0] tx_word,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  sync_n,
  output logic                  mosi,
  output logic                  active,
  output logic                  done,
  output logic [RES_BITS-1:0]   res_data
);
  localparam int DW = adc_ctrl_pkg::cnt_width(SCLK_HALF);
  localparam int BW = adc_ctrl_pkg::cnt_width(FRAME_BITS);
  localparam logic [DW-1:0] DIV_LAST = DW'(SCLK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

  logic [DW-1:0]         div;
  logic [BW-1:0]         bit_cnt;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      div      <= '0;
      bit_cnt  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      sclk     <= 1'b0;
      sync_n   <= 1'b1;
      mosi     <= 1'b0;
      active   <= 1'b0;
      done     <= 1'b0;
      res_data <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          sync_n  <= 1'b0;
          sclk    <= 1'b0;
          div     <= '0;
          bit_cnt <= '0;
          tx_sh   <= tx_word;
          mosi    <= tx_word[FRAME_BITS-1];
        end
      end else if (div != DIV_LAST) begin
        div <= div + 1'b1;
      end else begin
        div <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[FRAME_BITS-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == BIT_LAST) begin
            active   <= 1'b0;
            sync_n   <= 1'b1;
            done     <= 1'b1;
            res_data <= rx_sh[RES_BITS-1:0];
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
            mosi    <= tx_sh[FRAME_BITS-2];
          end
        end
      end
    end
  end

  // R4
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !sync_n);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  valid_at_close_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (sync_n && $past(!sync_n)));

endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl #(
  parameter int SAMPLE_PERIOD = 1250,
  parameter int START_W       = 25,
  parameter int ACQ_CYC       = 100,
  parameter int SCLK_HALF     = 2,
  parameter int FRAME_BITS    = 16,
  parameter int RES_BITS      = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic                  sw_start,
  input  logic [FRAME_BITS-1:0] ctrl_word,
  input  logic                  busy,
  input  logic                  miso,
  output logic                  conv_start,
  output logic                  sclk,
  output logic                  sync_n,
  output logic                  mosi,
  output logic                  res_valid,
  output logic [RES_BITS-1:0]   res_data,
  output logic                  overrun
);
  localparam int FRAME_CYC  = 2 * SCLK_HALF * FRAME_BITS;
  localparam int MIN_PERIOD = START_W + ACQ_CYC + FRAME_CYC + 4;

  // R7
  initial begin
    period_fit_chk: assert (SAMPLE_PERIOD >= MIN_PERIOD)
      else $error("sample period shorter than strobe + acquisition + frame");
  end

  logic busy_m, busy_s;
  logic tick, frame_go, frame_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_m <= 1'b0;
      busy_s <= 1'b0;
    end else begin
      busy_m <= busy;
      busy_s <= busy_m;
    end
  end

  period_timer #(
    .SAMPLE_PERIOD(SAMPLE_PERIOD)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .busy_s  (busy_s),
    .tick    (tick),
    .overrun (overrun)
  );

  conv_sequencer #(
    .START_W (START_W),
    .ACQ_CYC (ACQ_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .sw_mode    (sw_start),
    .busy_s     (busy_s),
    .frame_busy (frame_busy),
    .frame_done (res_valid),
    .conv_start (conv_start),
    .frame_go   (frame_go)
  );

  serial_frame #(
    .FRAME_BITS (FRAME_BITS),
    .RES_BITS   (RES_BITS),
    .SCLK_HALF  (SCLK_HALF)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .go       (frame_go),
    .tx_word  (ctrl_word),
    .miso     (miso),
    .sclk     (sclk),
    .sync_n   (sync_n),
    .mosi     (mosi),
    .active   (frame_busy),
    .done     (res_valid),
    .res_data (res_data)
  );

endmodule

// File: tb/adc_sample_ctrl_tb.sv
`timescale 1ns/1ps
module adc_sample_ctrl_tb;
  localparam int PERIOD = 1250;
  localparam int STW    = 25;
  localparam int ACQ    = 100;
  localparam logic [15:0] CWORD = 16'hC3A5;
  localparam logic [11:0] SAMPLES [8] = '{12'h000, 12'hFFF, 12'hA5A, 12'h5A5,
                                          12'h001, 12'h800, 12'h7FF, 12'h123};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic sw_start = 1'b0;
  logic [15:0] ctrl_word = CWORD;
  logic busy = 1'b0;
  logic miso = 1'b0;
  logic conv_start, sclk, sync_n, mosi, res_valid, overrun;
  logic [11:0] res_data;

  always #2 clk = ~clk;

  adc_sample_ctrl u_dut (
    .clk(clk), .rst(rst), .enable(enable), .sw_start(sw_start),
    .ctrl_word(ctrl_word), .busy(busy), .miso(miso),
    .conv_start(conv_start), .sclk(sclk), .sync_n(sync_n), .mosi(mosi),
    .res_valid(res_valid), .res_data(res_data), .overrun(overrun)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model and port monitor, all at the falling clock edge
  int conv_len = 100;
  int mph = 0, mdly = 0, mcl = 0, cidx = 0;
  logic [11:0] conv_val [64];
  logic [15:0] read_word = 16'h0000, sh = 16'h0000, mw = 16'h0000;
  logic prev_cs = 0, prev_sync = 1, prev_sclk = 0, prev_busy = 0, prev_valid = 0;
  int cyc = 0, cs_count = 0, cs_w = 0, pw_err = 0, last_rise = -1, last_iv = 0;
  int since_fall = 1000000, gap_err = 0, gap_min = 1000000;
  int ovl_err = 0, word_err = 0, rise_err = 0, rises = 0, frames = 0;
  int vcnt = 0, valid_err = 0;
  logic [11:0] got [64];

  always @(negedge clk) begin
    cyc++;
    // conversion-start strobe
    if (conv_start && !prev_cs) begin
      cs_count++;
      if (last_rise >= 0) last_iv = cyc - last_rise;
      last_rise = cyc;
      if (since_fall < gap_min) gap_min = since_fall;
      if (since_fall < ACQ) gap_err++;
      cs_w = 0;
    end
    if (conv_start) cs_w++;
    if (!conv_start && prev_cs && cs_w != STW) pw_err++;
    // frame
    if (!sync_n && prev_sync) begin
      if (!sw_start && !busy) ovl_err++;
      sh = read_word; miso = sh[15]; rises = 0;
    end
    if (sclk && !prev_sclk) begin mw = {mw[14:0], mosi}; rises++; end
    if (!sclk && prev_sclk && !sync_n) begin sh = {sh[14:0], 1'b0}; miso = sh[15]; end
    if (sync_n && !prev_sync) begin
      frames++;
      if (mw != ctrl_word) word_err++;
      if (rises != 16) rise_err++;
    end
    if (res_valid) begin
      if (prev_valid || !(sync_n && !prev_sync)) valid_err++;
      if (vcnt < 64) got[vcnt] = res_data;
      vcnt++;
    end
    // busy model
    if (mph == 2) begin
      mcl--;
      if (mcl == 0) begin
        busy = 1'b0; mph = 0;
        read_word = {~cidx[3:0], conv_val[cidx % 64]};
        cidx++;
      end
    end else if (mph == 1) begin
      mdly--;
      if (mdly == 0) begin busy = 1'b1; mcl = conv_len; mph = 2; end
    end
    if (mph == 0 && ((!sw_start && conv_start && !prev_cs) ||
                     (sw_start && sync_n && !prev_sync))) begin
      conv_val[cidx % 64] = SAMPLES[cidx % 8];
      mph = 1; mdly = 2;
    end
    if (!busy && prev_busy) since_fall = 0;
    else if (since_fall < 1000000) since_fall++;
    prev_cs = conv_start; prev_sync = sync_n; prev_sclk = sclk;
    prev_busy = busy; prev_valid = res_valid;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    int v0, c0;
    repeat (6) @(negedge clk);
    // R10: outputs while reset is held
    check(!conv_start && sync_n && !sclk && !res_valid && !overrun, "R10 reset state",
          {conv_start, sync_n, sclk, res_valid, overrun}, 5'b01000);
    @(negedge clk) rst = 1'b0;
    // R11: nothing starts while disabled
    repeat (3000) @(negedge clk);
    check(cs_count == 0 && frames == 0, "R11 idle while disabled", cs_count + frames, 0);

    // hardware-start run
    enable = 1'b1;
    while (vcnt < 9) @(negedge clk);
    for (int k = 1; k < 9; k++)
      check(got[k] == SAMPLES[k-1], "R5 result vector", got[k], SAMPLES[k-1]);
    check(pw_err == 0 && cs_count >= 9, "R1 strobe width", pw_err, 0);
    check(ovl_err == 0, "R2 frame overlaps busy", ovl_err, 0);
    check(gap_err == 0 && gap_min >= ACQ, "R3 acquisition gap", gap_min, ACQ);
    check(word_err == 0 && rise_err == 0, "R4 frame shape", word_err + rise_err, 0);
    check(valid_err == 0, "R6 valid strobe", valid_err, 0);
    check(last_iv == PERIOD, "R7 start spacing", last_iv, PERIOD);
    check(!overrun, "R8 no false overrun", overrun, 0);

    // software-start run
    enable = 1'b0;
    repeat (2000) @(negedge clk);
    c0 = cs_count; v0 = vcnt;
    sw_start = 1'b1; ctrl_word = 16'h5A3C; enable = 1'b1;
    while (vcnt < v0 + 4) @(negedge clk);
    check(cs_count == c0, "R9 no strobe in sw mode", cs_count, c0);
    for (int k = v0; k < v0 + 4; k++)
      check(got[k] == conv_val[k-1], "R9 sw result", got[k], conv_val[k-1]);
    check(word_err == 0 && rise_err == 0, "R4 sw frame word", word_err + rise_err, 0);
    enable = 1'b0;
    repeat (2000) @(negedge clk);

    // overrun
    sw_start = 1'b0;
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    conv_len = 1400; enable = 1'b1;
    repeat (4000) @(negedge clk);
    check(overrun, "R8 overrun set", overrun, 1);
    enable = 1'b0; conv_len = 100;
    repeat (3000) @(negedge clk);
    check(overrun, "R8 overrun sticky", overrun, 1);
    rst = 1'b1; repeat (2) @(negedge clk);
    check(!overrun && sync_n && !conv_start, "R10 reset clears overrun", overrun, 0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule